// File: doc/BRIEF.md
# Configurable Four-Input Lookup Cell

This block is a single logic cell of a programmable fabric. Four routing multiplexers each pick one bit out of eight neighbouring signals. The four picked bits form an address into a 16-entry truth table, and the addressed entry is the cell's result. The result leaves the cell either directly or through a one-bit register, chosen by a mode bit. The register's output can then serve as a neighbour signal for adjacent cells.

All of the cell's personality is held in a 29-bit serial configuration chain: the truth table, the four 3-bit input selects and the output-mode bit. While the configuration enable is high, the chain shifts one bit per clock. The last bit of the chain is presented on the shift-out pin, so cells can be daisy-chained into one long programming path. Both the routing and the logic function are therefore fixed only after the chip is built. Every multiplexer is an AND-mask of the candidates against a one-hot decode, followed by an OR-collapse.

Top module: `lcell_top`

## Requirements
- R1: While reset is asserted and after it is released with no programming, `cell_o` and `cfg_so` are 0 (all configuration bits and the output register clear to 0).
- R2: On each rising clock edge with `cfg_en` high, `cfg_si` enters chain bit 0 and every chain bit moves up by one. `cfg_so` shows chain bit 28, so a bit appears on `cfg_so` exactly 29 enabled shifts after it entered.
- R3: Chain layout after a full load: bits 15..0 hold table entries 15..0. Bits 16+3i+2..16+3i hold the select of table input i (i = 0..3). Bit 28 is the output mode (1 = direct, 0 = registered). Shifting the 29-bit word most-significant bit first loads it.
- R4: Table input i equals `nbr_i[s]`, where s is the 3-bit select of input i.
- R5: The table result is entry k, where k = {in3, in2, in1, in0} with input 0 as the least significant bit.
- R6: In direct mode, `cell_o` equals the table result in the same cycle, with no clock edge in between.
- R7: In registered mode, `cell_o` takes the table result on the rising edge after the inputs change, and holds it until the next edge.
- R8: While `cfg_en` is high, the output register keeps its value whatever the inputs do.
- R9: While `cfg_en` is low, the chain contents do not change, whatever `cfg_si` carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the cell |
| nbr_i | input | 8 | Neighbouring single-bit signals offered to the input selectors |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_si | input | 1 | Configuration serial data in |
| cfg_so | output | 1 | Configuration serial data out (chain bit 28) |
| cell_o | output | 1 | Cell result, direct or registered by mode |

## Verification
A corrupted chain bit shows up in one of two ways. It either changes the cell's function for a specific subset of the 256 neighbour patterns, or it reappears on `cfg_so` when the chain is shifted out. An exhaustive sweep of neighbour patterns per configuration therefore exposes any bad table entry or select on the first pattern that addresses it. A serial readback exposes a bad stored bit within 29 shifts. A register that fails to hold or to load shows a wrong `cell_o` one edge after the offending cycle.

// File: rtl/lcell_pkg.sv
package lcell_pkg;

  typedef enum logic {
    OUT_REGISTERED = 1'b0,
    OUT_DIRECT     = 1'b1
  } lcell_omode_e;

  function automatic int unsigned lcell_chain_len(int unsigned n_in, int unsigned sel_w);
    return (32'd1 << n_in) + n_in * sel_w + 32'd1;
  endfunction

endpackage

// File: rtl/lcell_rst_sync.sv
module lcell_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[STAGES-1];

endmodule

// File: rtl/lcell_andor_mux.sv
module lcell_andor_mux #(
  parameter int unsigned N     = 8,
  parameter int unsigned W     = 1,
  parameter int unsigned SEL_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N*W-1:0]  data_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [W-1:0]    data_o
);

  logic [N-1:0]   onehot;
  logic [N*W-1:0] masked;

  // one-hot decode of the select code
  always_comb begin
    for (int j = 0; j < N; j++) begin
      onehot[j] = (sel_i == SEL_W'(j));
    end
  end

  // AND-mask stage: N*W gates
  for (genvar j = 0; j < N; j++) begin : g_mask
    assign masked[j*W +: W] = data_i[j*W +: W] & {W{onehot[j]}};
  end

  // OR-collapse stage: (N-1)*W gates
  always_comb begin
    data_o = masked[W-1:0];
    for (int j = 1; j < N; j++) begin
      data_o = data_o | masked[j*W +: W];
    end
  end

endmodule

// File: rtl/lcell_cfg_chain.sv
module lcell_cfg_chain #(
  parameter int unsigned LEN = 29
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_en,
  input  logic           si,
  output logic           so,
  output logic [LEN-1:0] cfg_o
);

  logic [LEN-1:0] chain_q;
  logic [LEN-1:0] chain_d;

  always_comb begin
    if (shift_en) chain_d = {chain_q[LEN-2:0], si};
    else          chain_d = chain_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign cfg_o = chain_q;
  assign so    = chain_q[LEN-1];

endmodule

// File: rtl/lcell_out_stage.sv
module lcell_out_stage
  import lcell_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold_i,
  input  lcell_omode_e mode_i,
  input  logic         lut_i,
  output logic         reg_o,
  output logic         cell_o
);

  logic reg_q;
  logic reg_d;
  logic reg_ce;

  assign reg_ce = ~hold_i;

  always_comb begin
    if (reg_ce) reg_d = lut_i;
    else        reg_d = reg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_q <= 1'b0;
    else        reg_q <= reg_d;
  end

  always_comb begin
    unique case (mode_i)
      OUT_DIRECT:     cell_o = lut_i;
      OUT_REGISTERED: cell_o = reg_q;
      default:        cell_o = reg_q;
    endcase
  end

  assign reg_o = reg_q;

endmodule

// File: rtl/lcell_top.sv
module lcell_top
  import lcell_pkg::*;
#(
  parameter int unsigned N_NBR    = 8,
  parameter int unsigned N_LUT_IN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_NBR-1:0] nbr_i,
  input  logic             cfg_en,
  input  logic             cfg_si,
  output logic             cfg_so,
  output logic             cell_o
);

  localparam int unsigned SEL_W     = (N_NBR > 1) ? $clog2(N_NBR) : 1;
  localparam int unsigned TBL_N     = 1 << N_LUT_IN;
  localparam int unsigned SEL_BASE  = TBL_N;
  localparam int unsigned MODE_BIT  = TBL_N + N_LUT_IN * SEL_W;
  localparam int unsigned CHAIN_LEN = lcell_chain_len(N_LUT_IN, SEL_W);

  logic                 rst_sync_n;
  logic [CHAIN_LEN-1:0] cfg_w;
  logic [N_LUT_IN-1:0]  lut_idx;
  logic                 lut_bit;
  logic                 reg_q;
  lcell_omode_e         out_mode;

  lcell_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lcell_cfg_chain #(.LEN(CHAIN_LEN)) u_chain (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .shift_en (cfg_en),
    .si       (cfg_si),
    .so       (cfg_so),
    .cfg_o    (cfg_w)
  );

  // one routing selector per table input
  for (genvar i = 0; i < N_LUT_IN; i++) begin : g_insel
    lcell_andor_mux #(.N(N_NBR), .W(1), .SEL_W(SEL_W)) u_sel (
      .data_i (nbr_i),
      .sel_i  (cfg_w[SEL_BASE + i*SEL_W +: SEL_W]),
      .data_o (lut_idx[i])
    );
  end

  // truth table read: same AND-OR structure, addressed by the routed bits
  lcell_andor_mux #(.N(TBL_N), .W(1), .SEL_W(N_LUT_IN)) u_table (
    .data_i (cfg_w[TBL_N-1:0]),
    .sel_i  (lut_idx),
    .data_o (lut_bit)
  );

  assign out_mode = lcell_omode_e'(cfg_w[MODE_BIT]);

  lcell_out_stage u_out (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .hold_i (cfg_en),
    .mode_i (out_mode),
    .lut_i  (lut_bit),
    .reg_o  (reg_q),
    .cell_o (cell_o)
  );

endmodule

// File: rtl/lcell_top_chk.sv
module lcell_top_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_en,
  input logic cfg_si,
  input logic cfg_so,
  input logic chain0,
  input logic mode_direct,
  input logic lut_bit,
  input logic reg_q,
  input logic cell_o
);

  AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> (chain0 == $past(cfg_si))); // R2

  AST_CHAIN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> ($stable(cfg_so) && $stable(chain0))); // R9

  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> $stable(reg_q)); // R8

  AST_REG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> (reg_q == $past(lut_bit))); // R7

  AST_DIRECT_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    mode_direct |-> (cell_o == lut_bit)); // R6

endmodule

bind lcell_top lcell_top_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .cfg_en      (cfg_en),
  .cfg_si      (cfg_si),
  .cfg_so      (cfg_so),
  .chain0      (cfg_w[0]),
  .mode_direct (cfg_w[MODE_BIT]),
  .lut_bit     (lut_bit),
  .reg_q       (reg_q),
  .cell_o      (cell_o)
);

// File: tb/lcell_top_bench.sv
`timescale 1ns/1ps
module lcell_top_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] nbr_i;
  logic       cfg_en;
  logic       cfg_si;
  logic       cfg_so;
  logic       cell_o;

  int checks   = 0;
  int failures = 0;

  always #2 clk = ~clk; // 250 MHz

  lcell_top u_lcell_top (
    .clk    (clk),
    .rst_n  (rst_n),
    .nbr_i  (nbr_i),
    .cfg_en (cfg_en),
    .cfg_si (cfg_si),
    .cfg_so (cfg_so),
    .cell_o (cell_o)
  );

  function automatic logic [28:0] mk(input logic [15:0] tbl, input logic [2:0] s0,
                                     input logic [2:0] s1, input logic [2:0] s2,
                                     input logic [2:0] s3, input logic direct);
    return {direct, s3, s2, s1, s0, tbl};
  endfunction

  function automatic logic model(input logic [28:0] w, input logic [7:0] v);
    logic [3:0] k;
    for (int i = 0; i < 4; i++) k[i] = v[w[16 + 3*i +: 3]];
    return w[k];
  endfunction

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic program_word(input logic [28:0] w);
    for (int k = 28; k >= 0; k--) begin
      @(negedge clk); cfg_en = 1'b1; cfg_si = w[k];
    end
    @(negedge clk); cfg_en = 1'b0; cfg_si = 1'b0;
  endtask

  // R2 R3: shift in nw while checking the old contents come out MSB first
  task automatic shift_readback(input logic [28:0] old_w, input logic [28:0] nw);
    for (int k = 28; k >= 0; k--) begin
      @(negedge clk);
      check(cfg_so, old_w[k], "R2 R3 readback");
      cfg_en = 1'b1; cfg_si = nw[k];
    end
    @(negedge clk); cfg_en = 1'b0; cfg_si = 1'b0;
  endtask

  // R4 R5 R6 R7: all 256 neighbour patterns
  task automatic sweep(input logic [28:0] w);
    for (int v = 0; v < 256; v++) begin
      @(negedge clk); nbr_i = v[7:0];
      if (w[28]) begin
        #1 check(cell_o, model(w, v[7:0]), "R4 R5 R6 direct");
      end else begin
        @(posedge clk); #1 check(cell_o, model(w, v[7:0]), "R4 R5 R7 registered");
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [28:0] w_and, w_xor, w_reg, w_keep, w_last, w_cur;
    void'($urandom(32'd7));
    rst_n = 1'b0; cfg_en = 1'b0; cfg_si = 1'b0; nbr_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(cell_o, 1'b0, "R1 in reset");
    check(cfg_so, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(cell_o, 1'b0, "R1 after release");
    check(cfg_so, 1'b0, "R1 after release");

    // AND of neighbours 0..3, direct
    w_and = mk(16'h8000, 3'd0, 3'd1, 3'd2, 3'd3, 1'b1);
    program_word(w_and);
    sweep(w_and);

    // XOR with random selects, loaded while reading back the AND word
    w_xor = mk(16'h6996, 3'($urandom), 3'($urandom), 3'($urandom), 3'($urandom), 1'b1);
    shift_readback(w_and, w_xor);
    sweep(w_xor);
    w_cur = w_xor;

    // random tables, alternating direct and registered
    for (int t = 0; t < 4; t++) begin
      logic [28:0] w_rnd;
      w_rnd = mk(16'($urandom), 3'($urandom), 3'($urandom), 3'($urandom),
                 3'($urandom), t[0]);
      program_word(w_rnd);
      sweep(w_rnd);
      w_cur = w_rnd;
    end

    // R7 latency: AND of neighbours 1,2,3,0, registered; select of input 3 is 0
    w_reg = mk(16'h8000, 3'd1, 3'd2, 3'd3, 3'd0, 1'b0);
    program_word(w_reg);
    @(negedge clk); nbr_i = 8'h00;
    @(negedge clk);
    check(cell_o, 1'b0, "R7 settled low");
    nbr_i = 8'h0F;
    #1 check(cell_o, 1'b0, "R7 no change before edge");
    @(posedge clk); #1 check(cell_o, 1'b1, "R7 loads at edge");

    // R8: three shifts keep the mode bit at 0 (old bits 27..25 are zero)
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); cfg_en = 1'b1; cfg_si = 1'b0; nbr_i = 8'(k);
      @(posedge clk); #1 check(cell_o, 1'b1, "R8 register holds");
    end
    @(negedge clk); cfg_en = 1'b0;

    // R9: random serial data with enable low must not disturb the chain
    w_keep = mk(16'($urandom), 3'($urandom), 3'($urandom), 3'($urandom), 3'($urandom), 1'b0);
    program_word(w_keep);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk); cfg_si = 1'($urandom); nbr_i = 8'($urandom);
    end
    @(negedge clk); cfg_si = 1'b0;
    w_last = mk(16'($urandom), 3'($urandom), 3'($urandom), 3'($urandom), 3'($urandom), 1'b1);
    shift_readback(w_keep, w_last); // R9 contents unchanged
    sweep(w_last);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule